// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs a single DMA channel. Software loads a source pointer, a destination pointer, a 24-bit unit count, a 5-bit request type and a control/status word. Once the channel is armed, each unit goes out as one read request at the source pointer and then one write request at the destination pointer. After each unit the enabled pointers advance by the unit size in bytes and the count drops by one. The final unit raises the completion flag. A bus address error or a bus halt stops the channel and is latched as a status bit.

The unit size code covers 1, 2, 4, 16 and 32 bytes. The port widths for the read side and the write side are separate fields, and they are passed to the bus alongside the unit code. Request type 8 starts on its own. Every other type waits for the peripheral condition input. In block mode the channel runs unit after unit without looking at the request again. In single mode it goes back to idle after every unit and waits for a fresh request.

The channel interrupt is routed into a slot of a shared pending vector, where the slot index falls as the channel number rises. The channel's error conditions are also exposed in the bit positions that a global control word uses for them.

Top module: `dma_chan_seq`

## Requirements
- R1: Register select codes are 0 source, 1 destination, 2 count, 3 request type, 4 control; other codes read zero. The count reads back only bits 23..0, the request type only bits 4..0, and the control word only bits 23, 22, 15..12, 10..8, 7 and 4..0. All of these are zero after reset.
- R2: A transfer starts only when all of the following hold: control bit 0 (enable) is set, the global enable input is high, the count is nonzero, no stop bit is set, and either the request type is 8 or the peripheral request input is high.
- R3: Each unit is one read beat at the source pointer followed by one write beat at the destination pointer. bus_size carries control bits 10..8. bus_width carries bits 15..14 on the read beat and bits 13..12 on the write beat (0 = 32-bit, 1 = 8-bit, 2 = 16-bit).
- R4: After a completed unit, the source pointer advances when control bit 23 is set and the destination pointer advances when bit 22 is set. The step is the unit size in bytes: code 0 is 4, code 1 is 1, code 2 is 2, code 3 is 16, code 4 is 32.
- R5: Every completed unit decrements the count by one. The unit that brings the count to zero sets control bit 3 (complete) and ends the transfer.
- R6: With control bit 7 set (block mode), units follow one another without a request. With bit 7 clear (single mode), the channel returns to idle after each unit and starts the next unit only on a new request.
- R7: An address error on a beat sets control bit 4 and stops the channel. The count and both pointers keep their values from before that unit.
- R8: A halt on a beat sets control bit 2 and stops the channel.
- R9: While any of control bits 4, 3 or 2 is set, no transfer starts, even if the same write also sets the enable bit.
- R10: irq is high exactly when control bit 1 is set and bit 3 or bit 4 is set. A halt alone does not raise it.
- R11: irq_pend carries irq at bit 15 minus the channel number, and all its other bits are zero. err_flags bit 3 mirrors the halt bit and bit 2 mirrors the address-error bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global DMA enable |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| periph_req | input | 1 | Peripheral request condition |
| bus_req | output | 1 | Bus beat request |
| bus_rd | output | 1 | 1 for a read beat, 0 for a write beat |
| bus_addr | output | AW | Beat address |
| bus_size | output | 3 | Transfer unit code |
| bus_width | output | 2 | Port width code of the active side |
| bus_ack | input | 1 | Beat accepted |
| bus_aerr | input | 1 | Beat address error |
| bus_halt | input | 1 | Beat halted |
| irq | output | 1 | Channel interrupt |
| irq_pend | output | PEND_W | Pending vector slot for this channel |
| err_flags | output | 4 | Halt at bit 3, address error at bit 2 |

## Verification
The bench goes after the following corner cases.
- **Burst step size.** It runs the 16- and 32-byte unit codes, each with only one pointer incrementing. A design that stepped by the port width, or that moved a pointer whose increment bit is clear, would miss the expected beat addresses.
- **Enable with a stale stop bit.** It writes enable together with a stop bit that is still set, and separately arms a zero count. A design that started in either case would issue a beat the scoreboard never expected.
- **Errors mid-transfer.** It injects an address error on a write beat and a halt on the first read. A design that committed the partial unit would show a decremented count or advanced pointers. A design that raised the interrupt on a halt would show irq high.
- **Single mode without a fresh request.** It gives single mode a one-cycle request pulse. A design that kept running without a new request would emit extra beats.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_st_e;

    // register select codes
    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_CNT  = 3'd2;
    localparam logic [2:0] SEL_RTYP = 3'd3;
    localparam logic [2:0] SEL_CTRL = 3'd4;

    // control word bit positions
    localparam int B_SINC = 23;
    localparam int B_DINC = 22;
    localparam int B_BLK  = 7;
    localparam int B_AER  = 4;
    localparam int B_DONE = 3;
    localparam int B_HLT  = 2;
    localparam int B_IEN  = 1;
    localparam int B_EN   = 0;

    localparam logic [31:0] CTRL_KEEP = 32'h00C0_F79F;
    localparam logic [4:0]  RT_SELF   = 5'd8;

    function automatic logic [5:0] unit_bytes(input logic [2:0] code);
        case (code)
            3'd1:    unit_bytes = 6'd1;
            3'd2:    unit_bytes = 6'd2;
            3'd3:    unit_bytes = 6'd16;
            3'd4:    unit_bytes = 6'd32;
            default: unit_bytes = 6'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int AW = 32
)(
    input  logic [AW-1:0] addr_i,
    input  logic          inc_i,
    input  logic [5:0]    bytes_i,
    output logic [AW-1:0] addr_o
);
    always_comb begin
        addr_o = addr_i;
        if (inc_i) addr_o = addr_i + AW'(bytes_i);
    end
endmodule

// File: rtl/dma_pend_map.sv
module dma_pend_map #(
    parameter int PEND_W = 16,
    parameter int CH_ID  = 0
)(
    input  logic              irq_i,
    output logic [PEND_W-1:0] pend_o
);
    localparam int SLOT = PEND_W - 1 - CH_ID;

    generate
        for (genvar i = 0; i < PEND_W; i++) begin : g_slot
            if (i == SLOT) begin : g_hit
                assign pend_o[i] = irq_i;
            end else begin : g_miss
                assign pend_o[i] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int CH_ID  = 2,
    parameter int AW     = 32,
    parameter int CW     = 24,
    parameter int PEND_W = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              periph_req,
    output logic              bus_req,
    output logic              bus_rd,
    output logic [AW-1:0]     bus_addr,
    output logic [2:0]        bus_size,
    output logic [1:0]        bus_width,
    input  logic              bus_ack,
    input  logic              bus_aerr,
    input  logic              bus_halt,
    output logic              irq,
    output logic [PEND_W-1:0] irq_pend,
    output logic [3:0]        err_flags
);
    localparam int RW   = 32;
    localparam int NPTR = 2;

    typedef struct packed {
        seq_st_e       st;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [4:0]    rtyp;
        logic [RW-1:0] ctrl;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          stopped;
    logic          go;
    logic          idle;
    logic          beat_err;
    logic [5:0]    step_b;
    logic [AW-1:0] ptr_cur [NPTR];
    logic          ptr_inc [NPTR];
    logic [AW-1:0] ptr_nxt [NPTR];

    // observation points for the bound checker
    logic [CW-1:0] cnt_q;
    logic [3:0]    stat_q;
    logic          blk_q;

    assign cnt_q  = seq_q.cnt;
    assign stat_q = seq_q.ctrl[4:1];
    assign blk_q  = seq_q.ctrl[B_BLK];

    assign step_b     = unit_bytes(seq_q.ctrl[10:8]);
    assign ptr_cur[0] = seq_q.src;
    assign ptr_cur[1] = seq_q.dst;
    assign ptr_inc[0] = seq_q.ctrl[B_SINC];
    assign ptr_inc[1] = seq_q.ctrl[B_DINC];

    generate
        for (genvar p = 0; p < NPTR; p++) begin : g_ptr
            dma_addr_step #(.AW(AW)) step_i (
                .addr_i  (ptr_cur[p]),
                .inc_i   (ptr_inc[p]),
                .bytes_i (step_b),
                .addr_o  (ptr_nxt[p])
            );
        end
    endgenerate

    assign idle     = (seq_q.st == ST_IDLE);
    assign stopped  = seq_q.ctrl[B_AER] | seq_q.ctrl[B_DONE] | seq_q.ctrl[B_HLT];
    assign go       = seq_q.ctrl[B_EN] && !stopped && glb_en && (seq_q.cnt != '0)
                      && ((seq_q.rtyp == RT_SELF) || periph_req);
    assign beat_err = bus_aerr | bus_halt;

    always_comb begin
        seq_d = seq_q;

        // software side: pointer, count and type writes land only while idle
        if (reg_we) begin
            case (reg_sel)
                SEL_SRC:  if (idle) seq_d.src  = reg_wdata[AW-1:0];
                SEL_DST:  if (idle) seq_d.dst  = reg_wdata[AW-1:0];
                SEL_CNT:  if (idle) seq_d.cnt  = reg_wdata[CW-1:0];
                SEL_RTYP: if (idle) seq_d.rtyp = reg_wdata[4:0];
                SEL_CTRL: seq_d.ctrl = reg_wdata & CTRL_KEEP;
                default: ;
            endcase
        end

        // hardware side
        case (seq_q.st)
            ST_IDLE: begin
                if (go) seq_d.st = ST_RD;
            end
            ST_RD: begin
                if (beat_err) begin
                    seq_d.ctrl[B_AER] = seq_d.ctrl[B_AER] | bus_aerr;
                    seq_d.ctrl[B_HLT] = seq_d.ctrl[B_HLT] | bus_halt;
                    seq_d.st          = ST_IDLE;
                end else if (bus_ack) begin
                    seq_d.st = ST_WR;
                end
            end
            ST_WR: begin
                if (beat_err) begin
                    seq_d.ctrl[B_AER] = seq_d.ctrl[B_AER] | bus_aerr;
                    seq_d.ctrl[B_HLT] = seq_d.ctrl[B_HLT] | bus_halt;
                    seq_d.st          = ST_IDLE;
                end else if (bus_ack) begin
                    seq_d.src = ptr_nxt[0];
                    seq_d.dst = ptr_nxt[1];
                    seq_d.cnt = seq_q.cnt - CW'(1);
                    if (seq_q.cnt == CW'(1)) begin
                        seq_d.ctrl[B_DONE] = 1'b1;
                        seq_d.st           = ST_IDLE;
                    end else if (seq_q.ctrl[B_BLK] && seq_d.ctrl[B_EN] && glb_en) begin
                        seq_d.st = ST_RD;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_SRC:  reg_rdata = RW'(seq_q.src);
            SEL_DST:  reg_rdata = RW'(seq_q.dst);
            SEL_CNT:  reg_rdata = RW'(seq_q.cnt);
            SEL_RTYP: reg_rdata = RW'(seq_q.rtyp);
            SEL_CTRL: reg_rdata = seq_q.ctrl;
            default:  reg_rdata = '0;
        endcase
    end

    assign bus_req   = !idle;
    assign bus_rd    = (seq_q.st == ST_RD);
    assign bus_addr  = bus_rd ? seq_q.src : seq_q.dst;
    assign bus_size  = seq_q.ctrl[10:8];
    assign bus_width = bus_rd ? seq_q.ctrl[15:14] : seq_q.ctrl[13:12];
    assign irq       = seq_q.ctrl[B_IEN] & (seq_q.ctrl[B_DONE] | seq_q.ctrl[B_AER]);
    assign err_flags = {seq_q.ctrl[B_HLT], seq_q.ctrl[B_AER], 2'b00};

    dma_pend_map #(.PEND_W(PEND_W), .CH_ID(CH_ID)) pend_i (
        .irq_i  (irq),
        .pend_o (irq_pend)
    );

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
    parameter int CH_ID  = 2,
    parameter int CW     = 24,
    parameter int PEND_W = 16
)(
    input logic              clk,
    input logic              rst_n,
    input logic              glb_en,
    input logic              reg_we,
    input logic              bus_req,
    input logic              bus_rd,
    input logic              bus_ack,
    input logic              bus_aerr,
    input logic              bus_halt,
    input logic              irq,
    input logic [PEND_W-1:0] irq_pend,
    input logic [CW-1:0]     cnt,
    input logic [3:0]        stat,
    input logic              blk
);
    // stat: [3] addr error, [2] complete, [1] halt, [0] irq enable
    logic good_wr;
    assign good_wr = bus_req && !bus_rd && bus_ack && !bus_aerr && !bus_halt;

    a_r2_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && !glb_en) |=> !bus_req);

    a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_rd && bus_ack && !bus_aerr && !bus_halt) |=> (bus_req && !bus_rd));

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        good_wr |=> (cnt == $past(cnt) - CW'(1)));

    a_r6_single_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && !blk) |=> !bus_req);

    a_r7_aerr_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_aerr) |=> ($stable(cnt) && !bus_req && stat[3]));

    a_r8_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_halt) |=> (stat[1] && !bus_req));

    a_r9_stopped_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && (|stat[3:1])) |=> !bus_req);

    a_r10_aerr_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_aerr && stat[0] && !reg_we) |=> irq);

    a_r11_pend_slot: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0(irq_pend) && (irq_pend[PEND_W-1-CH_ID] == irq)));

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.CH_ID(CH_ID), .CW(CW), .PEND_W(PEND_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .glb_en   (glb_en),
    .reg_we   (reg_we),
    .bus_req  (bus_req),
    .bus_rd   (bus_rd),
    .bus_ack  (bus_ack),
    .bus_aerr (bus_aerr),
    .bus_halt (bus_halt),
    .irq      (irq),
    .irq_pend (irq_pend),
    .cnt      (cnt_q),
    .stat     (stat_q),
    .blk      (blk_q)
);

// File: tb/dma_chan_seq_tb.sv
`timescale 1ns/1ps
module dma_chan_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        periph_req = 1'b0;
    logic        bus_req, bus_rd;
    logic [31:0] bus_addr;
    logic [2:0]  bus_size;
    logic [1:0]  bus_width;
    logic        bus_ack = 1'b0;
    logic        bus_aerr = 1'b0;
    logic        bus_halt = 1'b0;
    logic        irq;
    logic [15:0] irq_pend;
    logic [3:0]  err_flags;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct packed {
        logic        rd;
        logic [31:0] addr;
        logic [2:0]  size;
        logic [1:0]  width;
    } beat_t;

    beat_t exp_q[$];
    int    inj_left = 0;
    bit    inj_halt = 1'b0;

    always #2.5 clk = ~clk;

    dma_chan_seq #(.CH_ID(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .periph_req(periph_req),
        .bus_req(bus_req), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_width(bus_width), .bus_ack(bus_ack), .bus_aerr(bus_aerr), .bus_halt(bus_halt),
        .irq(irq), .irq_pend(irq_pend), .err_flags(err_flags)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] step_of(input logic [2:0] c);
        case (c)
            3'd0: return 32'd4;
            3'd1: return 32'd1;
            3'd2: return 32'd2;
            3'd3: return 32'd16;
            default: return 32'd32;
        endcase
    endfunction

    // driver: expected read and write beat of one unit
    task automatic push_unit(input logic [31:0] s, input logic [31:0] d, input logic [31:0] ctl);
        exp_q.push_back('{rd: 1'b1, addr: s, size: ctl[10:8], width: ctl[15:14]});
        exp_q.push_back('{rd: 1'b0, addr: d, size: ctl[10:8], width: ctl[13:12]});
    endtask

    // monitor and bus responder
    always @(negedge clk) begin
        if (rst_n && bus_req) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R2 unexpected beat: actual rd=%0b addr=%h expected no beat", bus_rd, bus_addr);
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                if (bus_rd !== e.rd || bus_addr !== e.addr || bus_size !== e.size || bus_width !== e.width) begin
                    n_err++;
                    $display("FAIL R3 beat: actual rd=%0b addr=%h size=%0d width=%0d expected rd=%0b addr=%h size=%0d width=%0d",
                             bus_rd, bus_addr, bus_size, bus_width, e.rd, e.addr, e.size, e.width);
                end
            end
            bus_ack = 1'b1; bus_aerr = 1'b0; bus_halt = 1'b0;
            if (inj_left > 0) begin
                if (inj_left == 1) begin
                    bus_ack = 1'b0;
                    if (inj_halt) bus_halt = 1'b1;
                    else          bus_aerr = 1'b1;
                end
                inj_left--;
            end
        end else begin
            bus_ack = 1'b0; bus_aerr = 1'b0; bus_halt = 1'b0;
        end
    end

    task automatic wr_reg(input logic [2:0] s, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] s, input logic [31:0] exp);
        @(negedge clk);
        reg_sel = s;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        chk("R2 queue drained", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c, input logic [31:0] rt);
        wr_reg(3'd4, 32'd0);
        wr_reg(3'd0, s);
        wr_reg(3'd1, d);
        wr_reg(3'd2, c);
        wr_reg(3'd3, rt);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 5; i++) rd_chk("R1 reset reg", 3'(i), 32'd0);
        chk("R1 reset bus_req", 32'(bus_req), 32'd0);
        chk("R10 reset irq", 32'(irq), 32'd0);

        // R1 masks, R9 enable with stop bits, R11 mapping
        glb_en = 1'b1;
        wr_reg(3'd2, 32'hFFFF_FFFF);
        wr_reg(3'd3, 32'hFFFF_FFFF);
        wr_reg(3'd4, 32'hFFFF_FFFF);
        rd_chk("R1 count width", 3'd2, 32'h00FF_FFFF);
        rd_chk("R1 type width", 3'd3, 32'h0000_001F);
        rd_chk("R1 ctrl mask", 3'd4, 32'h00C0_F79F);
        rd_chk("R1 unused select", 3'd6, 32'd0);
        settle(6);
        chk("R11 pend slot", 32'(irq_pend), 32'h0000_2000);
        chk("R11 err flags", 32'(err_flags), 32'hC);

        // main block transfer, R3 R4 R5 R10
        setup(32'h1000, 32'h2000, 32'd3, 32'd8);
        for (int u = 0; u < 3; u++) push_unit(32'h1000 + 4*u, 32'h2000 + 4*u, 32'h00C0_6083);
        wr_reg(3'd4, 32'h00C0_6083);
        settle(20);
        rd_chk("R4 src after", 3'd0, 32'h100C);
        rd_chk("R4 dst after", 3'd1, 32'h200C);
        rd_chk("R5 count zero", 3'd2, 32'd0);
        rd_chk("R5 done bit", 3'd4, 32'h00C0_608B);
        chk("R10 irq on done", 32'(irq), 32'd1);
        chk("R11 pend on done", 32'(irq_pend), 32'h0000_2000);

        // R4 unit sizes, source only increments, no irq enable
        foreach (step_of_list[k]) begin
            logic [31:0] c, b, ctl;
            c = step_of_list[k];
            b = step_of(c[2:0]);
            ctl = 32'h0080_0081 | (c << 8);
            setup(32'h4000, 32'h8000, 32'd2, 32'd8);
            push_unit(32'h4000, 32'h8000, ctl);
            push_unit(32'h4000 + b, 32'h8000, ctl);
            wr_reg(3'd4, ctl);
            settle(16);
            rd_chk("R4 src burst step", 3'd0, 32'h4000 + 2*b);
            rd_chk("R4 dst fixed", 3'd1, 32'h8000);
            chk("R10 no irq without enable", 32'(irq), 32'd0);
        end

        // R6 single mode with peripheral request
        setup(32'h100, 32'h200, 32'd3, 32'd20);
        wr_reg(3'd4, 32'h00C0_0001);
        settle(10);
        rd_chk("R6 no request no move", 3'd2, 32'd3);
        push_unit(32'h100, 32'h200, 32'h00C0_0001);
        @(negedge clk); periph_req = 1'b1;
        @(negedge clk); periph_req = 1'b0;
        settle(10);
        rd_chk("R6 one unit per request", 3'd2, 32'd2);
        push_unit(32'h104, 32'h204, 32'h00C0_0001);
        push_unit(32'h108, 32'h208, 32'h00C0_0001);
        periph_req = 1'b1;
        settle(20);
        periph_req = 1'b0;
        rd_chk("R6 single completes", 3'd2, 32'd0);

        // R2 zero count and global enable gate
        setup(32'h300, 32'h400, 32'd0, 32'd8);
        wr_reg(3'd4, 32'h0000_0081);
        settle(8);
        rd_chk("R2 zero count idle", 3'd4, 32'h0000_0081);
        glb_en = 1'b0;
        wr_reg(3'd2, 32'd2);
        settle(8);
        rd_chk("R2 global off holds", 3'd2, 32'd2);
        push_unit(32'h300, 32'h400, 32'h0000_0081);
        push_unit(32'h300, 32'h400, 32'h0000_0081);
        glb_en = 1'b1;
        settle(15);
        rd_chk("R2 runs when global on", 3'd2, 32'd0);

        // R9 enable written together with a stop bit
        setup(32'h300, 32'h400, 32'd1, 32'd8);
        wr_reg(3'd4, 32'h0000_0089);
        settle(8);
        rd_chk("R9 stop blocks start", 3'd2, 32'd1);
        push_unit(32'h300, 32'h400, 32'h0000_0081);
        wr_reg(3'd4, 32'h0000_0081);
        settle(10);
        rd_chk("R9 runs after clear", 3'd2, 32'd0);

        // R7 address error on fourth beat
        setup(32'h5000, 32'h6000, 32'd4, 32'd8);
        push_unit(32'h5000, 32'h6000, 32'h00C0_0083);
        push_unit(32'h5004, 32'h6004, 32'h00C0_0083);
        inj_halt = 1'b0; inj_left = 4;
        wr_reg(3'd4, 32'h00C0_0083);
        settle(15);
        rd_chk("R7 count kept", 3'd2, 32'd3);
        rd_chk("R7 src kept", 3'd0, 32'h5004);
        rd_chk("R7 dst kept", 3'd1, 32'h6004);
        rd_chk("R7 aer bit", 3'd4, 32'h00C0_0093);
        chk("R10 irq on aer", 32'(irq), 32'd1);
        chk("R11 err aer", 32'(err_flags), 32'h4);

        // R8 halt on first read
        setup(32'h7000, 32'h7800, 32'd2, 32'd8);
        exp_q.push_back('{rd: 1'b1, addr: 32'h7000, size: 3'd0, width: 2'd0});
        inj_halt = 1'b1; inj_left = 1;
        wr_reg(3'd4, 32'h00C0_0083);
        settle(10);
        rd_chk("R8 count kept", 3'd2, 32'd2);
        rd_chk("R8 halt bit", 3'd4, 32'h00C0_0087);
        chk("R10 no irq on halt", 32'(irq), 32'd0);
        chk("R11 err halt", 32'(err_flags), 32'h8);
        chk("R11 pend clear", 32'(irq_pend), 32'd0);

        finish_run();
    end

    logic [31:0] step_of_list [4] = '{32'd3, 32'd4, 32'd1, 32'd2};

endmodule